// File: doc/BRIEF.md
# Multi-Port GPIO Register Bank

This block is a memory-mapped general-purpose I/O controller. It holds up to seven ports of eight pins each behind a plain 32-bit register bus made of an address, a write strobe, write data and combinational read data. Every port has the same register set, repeated at a fixed 0x30-byte spacing: the synchronized pad levels (read-only), the output data, a two-bit drive mode for each pin, and a pull-up disable mask. The block turns these into three signals per pin for the pad ring: output level, output enable and pull-up enable.

A global control word at address 0x000 reports how many 8-pin ports are present and a version number. It also holds two writable bits. The low bit is brought out as a clock-request enable. Pad inputs pass through a two-flop synchronizer before software can read them. The asynchronous active-low reset is released synchronously inside the block.

Top module: `pinbank_gpio`

## Requirements
- R1: After reset, every stored register is 0. So no pad is driven, every pull-up is enabled, `clk_req` is 0, and the control word reads `{16'b0, NPORTS[6:0], VERSION[6:0], 2'b00}`.
- R2: Port p (0 ≤ p < NPORTS) occupies byte window p*0x30. Inside that window, offset 0x04 is input data, 0x08 is output data, 0x0C is pin mode and 0x10 is pull control. The control word sits at absolute address 0x000. Pin n of the pad vectors is bit n%8 of port n/8.
- R3: Control word bits 15:9 read NPORTS and bits 8:2 read VERSION; both are read-only. Bits 1:0 are read/write. `clk_req` equals bit 0.
- R4: The pin mode register holds 2 bits per pin, at bits [2k+1:2k] for pin k. Code 00 (input) never enables the driver and gives level 0. Code 01 (push-pull) always enables the driver and drives the output data bit.
- R5: Code 10 (open-drain) drives level 0 with the driver enabled when the data bit is 0, and releases the pad (enable 0, level 0) when the data bit is 1.
- R6: Code 11 (open-source) drives level 1 with the driver enabled when the data bit is 1, and releases the pad (enable 0, level 1) when the data bit is 0.
- R7: In the pull control register, bit k = 1 disables the pull-up of pin k and bit k = 0 enables it, so `pad_pu` is the inverse of the stored bit. Only bits 7:0 are stored; the other bits read 0.
- R8: The input data register returns `pad_in` after two clock edges of synchronization, in bits 7:0. Bits 31:8 read 0, and writes to this register change nothing.
- R9: Addresses that are unmapped read 0 and writes to them change neither registers nor pads. This covers window offsets 0x14 and above, offset 0x00 in ports other than 0, non-word-aligned addresses, and windows at or past NPORTS. Unused bits of the output and mode registers also read 0.
- R10: A write lands on the clock edge that samples it. The pad outputs and read data show the new value right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pad_in | input | NPORTS*8 | Pad input levels (asynchronous) |
| pad_out | output | NPORTS*8 | Pad output level |
| pad_oe | output | NPORTS*8 | Pad driver enable |
| pad_pu | output | NPORTS*8 | Pad pull-up enable |
| clk_req | output | 1 | Clock-request enable (control bit 0) |

## Verification
The bench builds the block with all seven ports, VERSION 7'h2A and a 12-bit address. This puts the last mapped window (0x120) and the first window past the end (0x150) within reach, and it makes the port-count field non-trivial (0x0EA8 at reset). A behavioural model tracks every register and the two-stage input pipeline. It is compared each cycle against read data and all 56 pins. Directed checks cover each drive code on separate ports, the pull-mask inversion, the exact synchronizer latency, and stray writes to unmapped offsets, misaligned addresses and the window past the end.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

  localparam int PINS_PER_PORT = 8;
  localparam int MAX_PORTS     = 7;
  localparam int PORT_STRIDE   = 48;
  localparam int BUS_W         = 32;
  localparam int MODE_W        = 2 * PINS_PER_PORT;

  localparam int OFF_CTRL = 0;
  localparam int OFF_IN   = 4;
  localparam int OFF_OUT  = 8;
  localparam int OFF_MODE = 12;
  localparam int OFF_PULL = 16;

  typedef enum logic [1:0] {
    PM_INPUT     = 2'b00,
    PM_PUSHPULL  = 2'b01,
    PM_OPENDRAIN = 2'b10,
    PM_OPENSRC   = 2'b11
  } pin_mode_e;

  typedef struct packed {
    logic drive;
    logic level;
  } pad_drv_t;

  function automatic pad_drv_t pad_drive(input pin_mode_e m, input logic d);
    pad_drv_t r;
    unique case (m)
      PM_INPUT:     begin r.drive = 1'b0; r.level = 1'b0; end
      PM_PUSHPULL:  begin r.drive = 1'b1; r.level = d;    end
      PM_OPENDRAIN: begin r.drive = ~d;   r.level = 1'b0; end
      PM_OPENSRC:   begin r.drive = d;    r.level = 1'b1; end
      default:      begin r.drive = 1'b0; r.level = 1'b0; end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pinbank_rst_sync.sv
module pinbank_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;

endmodule

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] meta_q, stab_q;
  logic [WIDTH-1:0] meta_d, stab_d;

  always_comb begin
    meta_d = din;
    stab_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= meta_d;
      stab_q <= stab_d;
    end
  end

  assign dout = stab_q;

  // edges seen since reset, saturating at 2, so the latency check never reaches into reset
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= 2'd0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (dout == $past(din, 2))); // R8

endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int         NPORTS  = 7,
  parameter logic [6:0] VERSION = 7'h2A,
  parameter int         ADDR_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output logic              claim,
  output logic              clk_req
);

  localparam logic [ADDR_W-1:0] CTRL_A   = ADDR_W'(OFF_CTRL);
  localparam logic [6:0]        CORES_RO = 7'(NPORTS);

  logic       sel;
  logic       bits_we;
  logic [1:0] bits_q, bits_d;

  assign sel     = (addr == CTRL_A);
  assign bits_we = wr_en & sel;
  assign claim   = sel;

  always_comb begin
    bits_d = bits_q;
    if (bits_we) bits_d = wdata[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bits_q <= 2'b00;
    else if (bits_we) bits_q <= bits_d;
  end

  always_comb begin
    rdata = '0;
    if (sel) rdata[15:0] = {CORES_RO, VERSION, bits_q};
  end

  assign clk_req = bits_q[0];

  AST_CTRL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bits_we & rst_n) |-> (bits_q == $past(wdata[1:0]))); // R3

  AST_CTRL_HOLDS_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(bits_we) && $past(rst_n)) |-> $stable(clk_req)); // R9

endmodule

// File: rtl/pinbank_port.sv
module pinbank_port
  import pinbank_pkg::*;
#(
  parameter int PORT_IDX = 0,
  parameter int ADDR_W   = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     wr_en,
  input  logic [BUS_W-1:0]         wdata,
  input  logic [PINS_PER_PORT-1:0] pins_sync,
  output logic [BUS_W-1:0]         rdata,
  output logic                     claim,
  output logic [PINS_PER_PORT-1:0] pad_out,
  output logic [PINS_PER_PORT-1:0] pad_oe,
  output logic [PINS_PER_PORT-1:0] pad_pu
);

  localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(PORT_IDX * PORT_STRIDE);
  localparam logic [ADDR_W-1:0] LIMIT_A = ADDR_W'((PORT_IDX + 1) * PORT_STRIDE);
  localparam logic [ADDR_W-1:0] IN_A    = ADDR_W'(OFF_IN);
  localparam logic [ADDR_W-1:0] OUT_A   = ADDR_W'(OFF_OUT);
  localparam logic [ADDR_W-1:0] MODE_A  = ADDR_W'(OFF_MODE);
  localparam logic [ADDR_W-1:0] PULL_A  = ADDR_W'(OFF_PULL);

  // window decode
  logic              in_window;
  logic [ADDR_W-1:0] local_off;
  logic              sel_in, sel_out, sel_mode, sel_pull;

  assign in_window = (addr >= BASE_A) && (addr < LIMIT_A);
  assign local_off = addr - BASE_A;
  assign sel_in    = in_window && (local_off == IN_A);
  assign sel_out   = in_window && (local_off == OUT_A);
  assign sel_mode  = in_window && (local_off == MODE_A);
  assign sel_pull  = in_window && (local_off == PULL_A);
  assign claim     = sel_in | sel_out | sel_mode | sel_pull;

  // clock enables
  logic out_we, mode_we, pull_we;
  assign out_we  = wr_en & sel_out;
  assign mode_we = wr_en & sel_mode;
  assign pull_we = wr_en & sel_pull;

  // storage
  logic [PINS_PER_PORT-1:0] out_q,  out_d;
  logic [MODE_W-1:0]        mode_q, mode_d;
  logic [PINS_PER_PORT-1:0] pull_q, pull_d;

  always_comb begin
    out_d  = out_q;
    mode_d = mode_q;
    pull_d = pull_q;
    if (out_we)  out_d  = wdata[PINS_PER_PORT-1:0];
    if (mode_we) mode_d = wdata[MODE_W-1:0];
    if (pull_we) pull_d = wdata[PINS_PER_PORT-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (out_we) out_q <= out_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_we) mode_q <= mode_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pull_q <= '0;
    else if (pull_we) pull_q <= pull_d;
  end

  // read mux
  always_comb begin
    rdata = '0;
    unique case (1'b1)
      sel_in:   rdata[PINS_PER_PORT-1:0] = pins_sync;
      sel_out:  rdata[PINS_PER_PORT-1:0] = out_q;
      sel_mode: rdata[MODE_W-1:0]        = mode_q;
      sel_pull: rdata[PINS_PER_PORT-1:0] = pull_q;
      default:  rdata = '0;
    endcase
  end

  assign pad_pu = ~pull_q;

  // per-pin drive
  for (genvar i = 0; i < PINS_PER_PORT; i++) begin : g_pin
    pin_mode_e pmode;
    pad_drv_t  drv;

    assign pmode      = pin_mode_e'(mode_q[2*i +: 2]);
    assign drv        = pad_drive(pmode, out_q[i]);
    assign pad_oe[i]  = drv.drive;
    assign pad_out[i] = drv.level;

    AST_INPUT_NEVER_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      (pmode == PM_INPUT) |-> !pad_oe[i]); // R4

    AST_OPEN_DRAIN_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (pmode == PM_OPENDRAIN && pad_oe[i]) |-> !pad_out[i]); // R5

    AST_OPEN_SOURCE_HIGH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (pmode == PM_OPENSRC && pad_oe[i]) |-> pad_out[i]); // R6
  end

  AST_OUT_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(out_we & rst_n) |-> (out_q == $past(wdata[PINS_PER_PORT-1:0]))); // R10

  AST_PULL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pull_we & rst_n) |-> (pad_pu == ~$past(wdata[PINS_PER_PORT-1:0]))); // R7

endmodule

// File: rtl/pinbank_gpio.sv
module pinbank_gpio
  import pinbank_pkg::*;
#(
  parameter int         NPORTS  = 7,
  parameter logic [6:0] VERSION = 7'h2A,
  parameter int         ADDR_W  = 12
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic                            bus_wr,
  input  logic [31:0]                     bus_wdata,
  output logic [31:0]                     bus_rdata,
  input  logic [NPORTS*PINS_PER_PORT-1:0] pad_in,
  output logic [NPORTS*PINS_PER_PORT-1:0] pad_out,
  output logic [NPORTS*PINS_PER_PORT-1:0] pad_oe,
  output logic [NPORTS*PINS_PER_PORT-1:0] pad_pu,
  output logic                            clk_req
);

  localparam int NPINS = NPORTS * PINS_PER_PORT;

  logic             rst_sync_n;
  logic [NPINS-1:0] pins_sync;
  logic [BUS_W-1:0] ctrl_rd;
  logic             ctrl_claim;
  logic [BUS_W-1:0] port_rd [NPORTS];
  logic [NPORTS-1:0] port_claim;

  pinbank_rst_sync u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_sync_n)
  );

  pinbank_sync #(.WIDTH(NPINS)) u_insync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   (pad_in),
    .dout  (pins_sync)
  );

  pinbank_ctrl #(
    .NPORTS  (NPORTS),
    .VERSION (VERSION),
    .ADDR_W  (ADDR_W)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .addr    (bus_addr),
    .wr_en   (bus_wr),
    .wdata   (bus_wdata),
    .rdata   (ctrl_rd),
    .claim   (ctrl_claim),
    .clk_req (clk_req)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    pinbank_port #(
      .PORT_IDX (p),
      .ADDR_W   (ADDR_W)
    ) u_port (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .addr      (bus_addr),
      .wr_en     (bus_wr),
      .wdata     (bus_wdata),
      .pins_sync (pins_sync[p*PINS_PER_PORT +: PINS_PER_PORT]),
      .rdata     (port_rd[p]),
      .claim     (port_claim[p]),
      .pad_out   (pad_out[p*PINS_PER_PORT +: PINS_PER_PORT]),
      .pad_oe    (pad_oe[p*PINS_PER_PORT +: PINS_PER_PORT]),
      .pad_pu    (pad_pu[p*PINS_PER_PORT +: PINS_PER_PORT])
    );
  end

  always_comb begin
    bus_rdata = ctrl_rd;
    for (int p = 0; p < NPORTS; p++) bus_rdata = bus_rdata | port_rd[p];
  end

  AST_WINDOWS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({ctrl_claim, port_claim})); // R2

  AST_UNCLAIMED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(ctrl_claim | (|port_claim)) |-> (bus_rdata == '0)); // R9

endmodule

// File: tb/tb_pinbank_gpio.sv
module tb_pinbank_gpio;

  localparam int NP    = 7;
  localparam int NPINS = NP * 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [11:0]      bus_addr;
  logic             bus_wr;
  logic [31:0]      bus_wdata;
  logic [31:0]      bus_rdata;
  logic [NPINS-1:0] pad_in;
  logic [NPINS-1:0] pad_out, pad_oe, pad_pu;
  logic             clk_req;

  int n_chk  = 0;
  int n_fail = 0;
  bit chk_en = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  pinbank_gpio #(.NPORTS(NP), .VERSION(7'h2A), .ADDR_W(12)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .clk_req(clk_req)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0]       m_out  [NP];
  logic [15:0]      m_mode [NP];
  logic [7:0]       m_pull [NP];
  logic [1:0]       m_ctrl;
  logic [NPINS-1:0] m_s1, m_s2;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin m_out[p] = 0; m_mode[p] = 0; m_pull[p] = 0; end
      m_ctrl = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      int a, p, o;
      m_s2 = m_s1;
      m_s1 = pad_in;
      a = int'(bus_addr); p = a / 48; o = a % 48;
      if (bus_wr) begin
        if (a == 0) m_ctrl = bus_wdata[1:0];
        else if (p < NP) begin
          if (o == 8)  m_out[p]  = bus_wdata[7:0];
          if (o == 12) m_mode[p] = bus_wdata[15:0];
          if (o == 16) m_pull[p] = bus_wdata[7:0];
        end
      end
    end
  end

  function automatic logic [31:0] exp_rdata(input int a);
    int p, o;
    p = a / 48; o = a % 48;
    if (a == 0) return {16'h0, 7'(NP), 7'h2A, m_ctrl};
    if (p >= NP) return 0;
    case (o)
      4:  return {24'h0, m_s2[p*8 +: 8]};
      8:  return {24'h0, m_out[p]};
      12: return {16'h0, m_mode[p]};
      16: return {24'h0, m_pull[p]};
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    #5;
    if (chk_en) begin
      logic [NPINS-1:0] e_oe, e_out, e_pu;
      for (int n = 0; n < NPINS; n++) begin
        logic [1:0] md;
        logic d;
        md = m_mode[n/8][2*(n%8) +: 2];
        d  = m_out[n/8][n%8];
        case (md)
          2'b00: begin e_oe[n] = 0;  e_out[n] = 0; end
          2'b01: begin e_oe[n] = 1;  e_out[n] = d; end
          2'b10: begin e_oe[n] = ~d; e_out[n] = 0; end
          default: begin e_oe[n] = d; e_out[n] = 1; end
        endcase
        e_pu[n] = ~m_pull[n/8][n%8];
      end
      chk("R2 model rdata", {32'h0, bus_rdata}, {32'h0, exp_rdata(int'(bus_addr))});
      chk("R10 model pad_oe", 64'(pad_oe), 64'(e_oe));
      chk("R10 model pad_out", 64'(pad_out), 64'(e_out));
      chk("R7 model pad_pu", 64'(pad_pu), 64'(e_pu));
      chk("R3 model clk_req", {63'h0, clk_req}, {63'h0, m_ctrl[0]});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    #5;
    chk(tag, {32'h0, bus_rdata}, {32'h0, e});
  endtask

  function automatic logic [7:0] sl(input logic [NPINS-1:0] v, input int p);
    return v[p*8 +: 8];
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    rst_n = 0; bus_addr = 0; bus_wr = 0; bus_wdata = 0; pad_in = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk_en = 1;

    // R1 reset state
    chk("R1 pad_oe", 64'(pad_oe), 64'h0);
    chk("R1 pad_pu", 64'(pad_pu), 64'(56'hFF_FFFF_FFFF_FFFF));
    chk("R1 clk_req", {63'h0, clk_req}, 64'h0);
    rd_chk(12'h000, 32'h0000_0EA8, "R1 ctrl reset");
    rd_chk(12'h0C8, 32'h0, "R1 out reg reset");

    // R3 control bits
    wr(12'h000, 32'hFFFF_FFFF);
    chk("R3 clk_req set", {63'h0, clk_req}, 64'h1);
    rd_chk(12'h000, 32'h0000_0EAB, "R3 ctrl rw bits");
    wr(12'h000, 32'h0000_0002);
    chk("R3 clk_req clear", {63'h0, clk_req}, 64'h0);
    rd_chk(12'h000, 32'h0000_0EAA, "R3 ctrl ro fields");

    // R4 push-pull and input on port 2 (base 0x060)
    wr(12'h06C, 32'hFFFF_0005);
    rd_chk(12'h06C, 32'h0000_0005, "R4 mode readback");
    wr(12'h068, 32'hFFFF_FF05);
    chk("R4 oe port2", 64'(sl(pad_oe, 2)), 64'h03);
    chk("R4 out port2", 64'(sl(pad_out, 2)), 64'h01);
    rd_chk(12'h068, 32'h0000_0005, "R9 out unused bits");

    // R5 open-drain on port 4 (base 0x0C0)
    wr(12'h0CC, 32'h0000_000A);
    wr(12'h0C8, 32'h0000_0002);
    chk("R5 oe port4", 64'(sl(pad_oe, 4)), 64'h01);
    chk("R5 out port4", 64'(sl(pad_out, 4)), 64'h00);

    // R6 open-source on port 6 (base 0x120)
    wr(12'h12C, 32'h0000_000F);
    wr(12'h128, 32'h0000_0002);
    chk("R6 oe port6", 64'(sl(pad_oe, 6)), 64'h02);
    chk("R6 out port6", 64'(sl(pad_out, 6)), 64'h03);

    // R7 pull control on port 1 (base 0x030)
    wr(12'h040, 32'hFFFF_FF5A);
    chk("R7 pu port1", 64'(sl(pad_pu, 1)), 64'hA5);
    rd_chk(12'h040, 32'h0000_005A, "R7 pull readback");

    // R8 input synchronizer on port 3 (base 0x090)
    @(negedge clk);
    bus_addr = 12'h094;
    pad_in[24 +: 8] = 8'hC3;
    @(posedge clk); #5;
    chk("R8 one edge", {32'h0, bus_rdata}, 64'h0);
    @(posedge clk); #5;
    chk("R8 two edges", {32'h0, bus_rdata}, 64'h0000_00C3);
    wr(12'h094, 32'hFFFF_FFFF);
    rd_chk(12'h094, 32'h0000_00C3, "R8 write ignored");

    // R9 unmapped addresses
    wr(12'h044, 32'hFFFF_FFFF);
    rd_chk(12'h044, 32'h0, "R9 offset 0x14");
    wr(12'h069, 32'hFFFF_FFFF);
    chk("R9 misaligned oe", 64'(sl(pad_oe, 2)), 64'h03);
    chk("R9 misaligned out", 64'(sl(pad_out, 2)), 64'h01);
    wr(12'h030, 32'h0000_0003);
    chk("R9 port1 offset0", {63'h0, clk_req}, 64'h0);
    rd_chk(12'h030, 32'h0, "R9 port1 offset0 read");
    wr(12'h158, 32'hFFFF_FFFF);
    rd_chk(12'h158, 32'h0, "R9 past last port");
    chk("R9 pads after stray", 64'(sl(pad_oe, 6)), 64'h02);

    // R10 write visible right after its edge
    @(negedge clk);
    bus_addr = 12'h068; bus_wdata = 32'h0; bus_wr = 1;
    @(posedge clk); #5;
    chk("R10 out drops", 64'(sl(pad_out, 2)), 64'h00);
    @(negedge clk);
    bus_wr = 0;

    // mixed traffic against the model
    for (int k = 0; k < 600; k++) begin
      int offs [9] = '{0, 4, 8, 12, 16, 20, 28, 32, 2};
      @(negedge clk);
      pad_in    = {$urandom, $urandom};
      bus_addr  = 12'(($urandom % 8) * 48 + offs[$urandom % 9]);
      bus_wr    = ($urandom % 2) == 1;
      bus_wdata = $urandom;
    end
    @(negedge clk);
    bus_wr = 0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule